// File: doc/BRIEF.md
# Packed Float-to-Int32 Converter

This block takes a 128-bit vector of floating-point lanes and turns each lane into a signed 32-bit integer. It handles two lane formats. In single-precision mode the vector holds four 32-bit floats and produces four integers. In double-precision mode it holds two 64-bit floats and produces two integers in the low half of the result, with the upper half cleared.

Rounding follows a 2-bit mode input. A truncate control overrides that mode and always chops toward zero. Two flags are produced for each vector. The invalid flag reports a NaN, an infinity or a result outside the signed 32-bit range. The inexact flag reports that fraction bits were discarded.

The converter has one register stage. A vector presented with `valid_i` high appears on the outputs on the following clock edge, and the outputs hold their value until the next valid vector.

Top module: `pk_f2i_conv`

## Requirements
- R1: With `dbl_i` low, each 32-bit lane k of `src_i` (bits [32k+31:32k]) is converted to a signed 32-bit integer placed in the same bit positions of `res_o`.
- R2: With `dbl_i` high, the 64-bit float in `src_i[63:0]` is converted into `res_o[31:0]` and the float in `src_i[127:64]` is converted into `res_o[63:32]`.
- R3: With `dbl_i` high, `res_o[127:64]` is zero whatever the upper source bits hold.
- R4: When `trunc_i` is low, an inexact value is rounded by `rnd_mode_i`. The encodings are 2'b00 nearest with ties to even, 2'b01 toward minus infinity, 2'b10 toward plus infinity and 2'b11 toward zero.
- R5: When `trunc_i` is high, every lane rounds toward zero regardless of `rnd_mode_i`.
- R6: A NaN lane, an infinite lane, or a lane whose rounded value lies outside [-2^31, 2^31-1] yields 32'h8000_0000 and sets `invalid_o`. `invalid_o` is the OR over the active lanes.
- R7: `inexact_o` is set when any active lane that is not invalid discards nonzero fraction bits. It is clear when every valid lane converts exactly.
- R8: A value that rounds to exactly -2^31 is a valid result, 32'h8000_0000, and does not set `invalid_o`.
- R9: `valid_o` equals `valid_i` delayed by one clock. `res_o` and both flags change only on an edge where `valid_i` was high, and they hold otherwise.
- R10: While `rst_ni` is low, `valid_o`, `res_o`, `invalid_o` and `inexact_o` are all zero.
- R11: Zero and subnormal inputs convert as values of magnitude below one. Zero is exact. A nonzero subnormal is inexact and gives 0, or ±1 where the directed mode rounds away from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Source vector is valid this cycle |
| dbl_i | input | 1 | 1: two double lanes, 0: four single lanes |
| trunc_i | input | 1 | Force rounding toward zero |
| rnd_mode_i | input | 2 | Rounding mode when not truncating |
| src_i | input | 128 | Packed floating-point source |
| valid_o | output | 1 | Result is valid |
| res_o | output | 128 | Packed signed 32-bit results |
| invalid_o | output | 1 | Some active lane was invalid |
| inexact_o | output | 1 | Some valid active lane was inexact |

## Verification
Exact halves such as ±0.5, 1.5 and 2.5 are swept through every rounding mode and through truncate. These separate ties-to-even from ties-away behaviour, and directed rounding from chopping. Values at the signed range edge are also applied: 2^31 - 0.5, -2^31 - 0.5, exactly -2^31 and 2^31. These show whether the overflow test is made after rounding and whether the negative limit is accepted. NaN, infinity, signed zero and subnormals check that the special-value and tiny-value paths are separate. Random lanes with exponents around the integer range, in both formats, are compared against a model built on real arithmetic, with garbage placed in the upper source half in double mode.

// File: rtl/pk_f2i_pkg.sv
package pk_f2i_pkg;
  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_DOWN      = 2'b01,
    RND_UP        = 2'b10,
    RND_ZERO      = 2'b11
  } rnd_mode_e;

  localparam int unsigned INT_W = 32;
  localparam int unsigned MAG_W = INT_W + 1;  // one headroom bit for overflow detection
endpackage

// File: rtl/f2i_round.sv
module f2i_round
  import pk_f2i_pkg::*;
(
  input  logic [MAG_W-1:0] mag_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  input  logic             sign_i,
  input  logic             trunc_i,
  input  rnd_mode_e        mode_i,
  input  logic             force_inv_i,
  output logic [INT_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [MAG_W:0] POS_MAX = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [MAG_W:0] NEG_MAX = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  logic             lost;
  logic             inc;
  logic [MAG_W:0]   rnd;
  logic             over;
  logic [INT_W-1:0] low;

  assign lost = guard_i | sticky_i;

  always_comb begin
    inc = 1'b0;
    if (!trunc_i) begin
      unique case (mode_i)
        RND_NEAR_EVEN: inc = guard_i & (sticky_i | mag_i[0]);
        RND_DOWN:      inc = sign_i & lost;
        RND_UP:        inc = ~sign_i & lost;
        default:       inc = 1'b0;
      endcase
    end
  end

  assign rnd  = {1'b0, mag_i} + {{MAG_W{1'b0}}, inc};
  assign over = sign_i ? (rnd > NEG_MAX) : (rnd > POS_MAX);
  assign low  = rnd[INT_W-1:0];

  assign invalid_o = force_inv_i | over;
  assign res_o     = invalid_o ? INDEF : (sign_i ? (~low + 1'b1) : low);
  assign inexact_o = lost & ~invalid_o;
endmodule

// File: rtl/f2i_lane.sv
module f2i_lane
  import pk_f2i_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] fp_i,
  input  logic                 trunc_i,
  input  rnd_mode_e            mode_i,
  output logic [INT_W-1:0]     res_o,
  output logic                 invalid_o,
  output logic                 inexact_o
);
  localparam int unsigned BIAS = 2**(EXP_W-1) - 1;
  localparam int unsigned FW   = MAN_W + 2;        // fraction bits kept
  localparam int unsigned XW   = MAG_W + FW;       // fixed-point width
  localparam int unsigned SW   = EXP_W + 2;        // signed exponent width
  localparam logic signed [SW-1:0] BIAS_S  = SW'(BIAS);
  localparam logic signed [SW-1:0] EXP_MAX = SW'(INT_W - 1);
  localparam logic signed [SW-1:0] EXP_MIN = SW'(-1);

  logic                    sign;
  logic [EXP_W-1:0]        ex;
  logic [MAN_W-1:0]        man;
  logic signed [SW-1:0]    uexp;
  logic                    special;
  logic                    big;
  logic                    tiny;
  logic [5:0]              sh;
  logic [XW-1:0]           fx;
  logic [MAG_W-1:0]        mag;
  logic                    guard;
  logic                    sticky;

  assign sign    = fp_i[EXP_W+MAN_W];
  assign ex      = fp_i[EXP_W+MAN_W-1:MAN_W];
  assign man     = fp_i[MAN_W-1:0];
  assign uexp    = $signed({2'b00, ex}) - BIAS_S;
  assign special = &ex;
  assign big     = uexp > EXP_MAX;
  assign tiny    = (ex == '0) || (uexp < EXP_MIN);
  // integer LSB sits at bit FW; significand LSB weight 2^(uexp-MAN_W) lands at uexp+2
  assign sh      = 6'(uexp + SW'(2));
  assign fx      = XW'({1'b1, man}) << sh;

  always_comb begin
    if (tiny) begin
      mag    = '0;
      guard  = 1'b0;
      sticky = (ex != '0) | (|man);
    end else begin
      mag    = fx[XW-1:FW];
      guard  = fx[FW-1];
      sticky = |fx[FW-2:0];
    end
  end

  f2i_round u_round (
    .mag_i       (mag),
    .guard_i     (guard),
    .sticky_i    (sticky),
    .sign_i      (sign),
    .trunc_i     (trunc_i),
    .mode_i      (mode_i),
    .force_inv_i (special | (big & ~tiny)),
    .res_o       (res_o),
    .invalid_o   (invalid_o),
    .inexact_o   (inexact_o)
  );
endmodule

// File: rtl/pk_f2i_conv.sv
module pk_f2i_conv
  import pk_f2i_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             dbl_i,
  input  logic             trunc_i,
  input  logic [1:0]       rnd_mode_i,
  input  logic [VEC_W-1:0] src_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam int unsigned SP_W     = 32;
  localparam int unsigned DP_W     = 64;
  localparam int unsigned SP_LANES = VEC_W / SP_W;
  localparam int unsigned DP_LANES = VEC_W / DP_W;

  rnd_mode_e mode;
  assign mode = rnd_mode_e'(rnd_mode_i);

  logic [INT_W-1:0]    sp_res [SP_LANES];
  logic [SP_LANES-1:0] sp_inv, sp_inx;
  logic [INT_W-1:0]    dp_res [DP_LANES];
  logic [DP_LANES-1:0] dp_inv, dp_inx;

  for (genvar g = 0; g < SP_LANES; g++) begin : g_sp
    f2i_lane #(.EXP_W(8), .MAN_W(23)) u_lane (
      .fp_i      (src_i[g*SP_W +: SP_W]),
      .trunc_i   (trunc_i),
      .mode_i    (mode),
      .res_o     (sp_res[g]),
      .invalid_o (sp_inv[g]),
      .inexact_o (sp_inx[g])
    );
  end

  for (genvar g = 0; g < DP_LANES; g++) begin : g_dp
    f2i_lane #(.EXP_W(11), .MAN_W(52)) u_lane (
      .fp_i      (src_i[g*DP_W +: DP_W]),
      .trunc_i   (trunc_i),
      .mode_i    (mode),
      .res_o     (dp_res[g]),
      .invalid_o (dp_inv[g]),
      .inexact_o (dp_inx[g])
    );
  end

  logic [VEC_W-1:0] nxt_res;
  logic             nxt_inv, nxt_inx;

  always_comb begin
    nxt_res = '0;
    if (dbl_i) begin
      for (int i = 0; i < DP_LANES; i++) nxt_res[i*INT_W +: INT_W] = dp_res[i];
      nxt_inv = |dp_inv;
      nxt_inx = |dp_inx;
    end else begin
      for (int i = 0; i < SP_LANES; i++) nxt_res[i*INT_W +: INT_W] = sp_res[i];
      nxt_inv = |sp_inv;
      nxt_inx = |sp_inx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      res_o     <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o     <= nxt_res;
        invalid_o <= nxt_inv;
        inexact_o <= nxt_inx;
      end
    end
  end
endmodule

// File: rtl/pk_f2i_conv_chk.sv
module pk_f2i_conv_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             dbl_i,
  input logic [7:0]       sp0_exp_i,
  input logic [10:0]      dp0_exp_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] res_o,
  input logic             invalid_o,
  input logic             inexact_o
);
  localparam logic [31:0] INDEF = 32'h8000_0000;

  a_r9_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r9_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(invalid_o) && $stable(inexact_o)));
  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dbl_i) |=> (res_o[VEC_W-1:VEC_W/2] == '0));
  a_r6_sp_special: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dbl_i && (&sp0_exp_i)) |=> (invalid_o && res_o[31:0] == INDEF));
  a_r6_dp_special: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dbl_i && (&dp0_exp_i)) |=> (invalid_o && res_o[31:0] == INDEF));
  a_r6_indef_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && invalid_o) |->
      (res_o[31:0] == INDEF || res_o[63:32] == INDEF ||
       res_o[95:64] == INDEF || res_o[127:96] == INDEF));
  a_r10_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && res_o == '0 && !invalid_o && !inexact_o));
endmodule

bind pk_f2i_conv pk_f2i_conv_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .dbl_i     (dbl_i),
  .sp0_exp_i (src_i[30:23]),
  .dp0_exp_i (src_i[62:52]),
  .valid_o   (valid_o),
  .res_o     (res_o),
  .invalid_o (invalid_o),
  .inexact_o (inexact_o)
);

// File: tb/pk_f2i_conv_test.sv
module pk_f2i_conv_test;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0, dbl_i = 1'b0, trunc_i = 1'b0;
  logic [1:0]   rnd_mode_i = 2'b00;
  logic [127:0] src_i = '0;
  logic         valid_o, invalid_o, inexact_o;
  logic [127:0] res_o;

  int total = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pk_f2i_conv uut (.*);

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic real sp_to_real(logic [31:0] b);
    real v;
    int  p;
    v = (b[30:23] == 0) ? real'(b[22:0]) : real'({1'b1, b[22:0]});
    p = (b[30:23] == 0) ? -149 : int'(b[30:23]) - 150;
    while (p > 0) begin v = v * 2.0; p--; end
    while (p < 0) begin v = v * 0.5; p++; end
    return b[31] ? -v : v;
  endfunction

  // reference for one lane; mode 00 nearest-even, 01 down, 10 up, 11 zero
  task automatic ref_lane(input real v, input bit special, input bit trunc,
                          input logic [1:0] mode, output logic [31:0] r,
                          output bit inv, output bit inx);
    real rr, f, d;
    inv = 0; inx = 0; r = 32'h8000_0000;
    if (special) begin inv = 1; return; end
    if (trunc || mode == 2'b11) rr = (v < 0.0) ? -$floor(-v) : $floor(v);
    else if (mode == 2'b01) rr = $floor(v);
    else if (mode == 2'b10) rr = $ceil(v);
    else begin
      f = $floor(v); d = v - f;
      if (d > 0.5) rr = f + 1.0;
      else if (d < 0.5) rr = f;
      else rr = ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
    end
    if (rr > 2147483647.0 || rr < -2147483648.0) begin inv = 1; return; end
    r = $rtoi(rr);
    inx = (rr != v);
  endtask

  task automatic ref_vec(input logic [127:0] s, input bit dbl, input bit trunc,
                         input logic [1:0] mode, output logic [127:0] er,
                         output bit einv, output bit einx);
    logic [31:0] r;
    bit inv, inx;
    er = '0; einv = 0; einx = 0;
    if (dbl) begin
      for (int i = 0; i < 2; i++) begin
        ref_lane($bitstoreal(s[i*64 +: 64]), &s[i*64+52 +: 11], trunc, mode, r, inv, inx);
        er[i*32 +: 32] = r; einv |= inv; einx |= inx;
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        ref_lane(sp_to_real(s[i*32 +: 32]), &s[i*32+23 +: 8], trunc, mode, r, inv, inx);
        er[i*32 +: 32] = r; einv |= inv; einx |= inx;
      end
    end
  endtask

  task automatic run_vec(logic [127:0] s, bit dbl, bit trunc, logic [1:0] mode, string tag);
    logic [127:0] er;
    bit einv, einx;
    ref_vec(s, dbl, trunc, mode, er, einv, einx);
    @(negedge clk_i);
    src_i = s; dbl_i = dbl; trunc_i = trunc; rnd_mode_i = mode; valid_i = 1;
    @(negedge clk_i);
    valid_i = 0;
    chk({tag, " R9 valid_o"}, 128'(valid_o), 128'(1));
    chk({tag, dbl ? " R2 result" : " R1 result"}, res_o, er);
    if (dbl) chk({tag, " R3 upper zero"}, 128'(res_o[127:64]), 128'(0));
    chk({tag, " R6 invalid"}, 128'(invalid_o), 128'(einv));
    chk({tag, " R7 inexact"}, 128'(inexact_o), 128'(einx));
  endtask

  function automatic logic [31:0] rnd_sp();
    logic [7:0] e;
    e = ($urandom % 16 == 0) ? 8'hFF : 8'(100 + $urandom % 60);
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  function automatic logic [63:0] rnd_dp();
    logic [10:0] e;
    e = ($urandom % 16 == 0) ? 11'h7FF : 11'(1000 + $urandom % 60);
    return {1'($urandom), e, 20'($urandom), 32'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    logic [127:0] ties;
    logic [127:0] garbage;
    void'($urandom(32'h5eed_f21e));
    repeat (2) @(negedge clk_i);
    // R10: reset state
    chk("R10 reset valid_o", 128'(valid_o), 128'(0));
    chk("R10 reset res_o", res_o, 128'(0));
    chk("R10 reset flags", 128'({invalid_o, inexact_o}), 128'(0));
    rst_ni = 1;

    ties = {32'h3FC0_0000, 32'h4020_0000, 32'hC020_0000, 32'hBF00_0000}; // 1.5 2.5 -2.5 -0.5
    // R4: nearest-even ties
    run_vec(ties, 0, 0, 2'b00, "R4 ties near-even");
    chk("R4 ties exact values", res_o, {32'd2, 32'd2, -32'sd2, 32'd0});
    run_vec(ties, 0, 0, 2'b01, "R4 ties down");
    run_vec(ties, 0, 0, 2'b10, "R4 ties up");
    run_vec(ties, 0, 0, 2'b11, "R4 ties zero");
    // R5: truncate overrides up mode
    run_vec(ties, 0, 1, 2'b10, "R5 trunc over up");
    chk("R5 trunc values", res_o, {32'd1, 32'd2, -32'sd2, 32'd0});
    // R6 / R8: NaN, +inf, 2^31, -2^31
    run_vec({32'h7FC0_0000, 32'h7F80_0000, 32'h4F00_0000, 32'hCF00_0000}, 0, 0, 2'b00, "R6 specials");
    chk("R8 neg limit lane", 128'(res_o[31:0]), 128'(32'h8000_0000));
    run_vec({32'h0, 32'h0, 32'h3F80_0000, 32'hCF00_0000}, 0, 0, 2'b00, "R8 neg limit only");
    chk("R8 no invalid", 128'(invalid_o), 128'(0));
    // R11: zero, -0, subnormals with up mode
    run_vec({32'h0, 32'h8000_0000, 32'h0000_0001, 32'h8000_0001}, 0, 0, 2'b10, "R11 tiny up");
    chk("R11 tiny up values", res_o, {32'd0, 32'd0, 32'd1, 32'd0});
    run_vec({32'h0, 32'h8000_0000, 32'h0, 32'h0}, 0, 0, 2'b01, "R11 zero exact");
    run_vec({64'h0, 64'h8000_0000_0000_0001}, 1, 0, 2'b01, "R11 dp subnormal down");
    // R2 / R3 / R6 double range edge with garbage upper half
    garbage = {$urandom, $urandom, 64'h0};
    run_vec(garbage | {64'h0, $realtobits(-2147483648.5), $realtobits(2147483647.5)} >> 0, 1, 0, 2'b00, "R6 dp edge near");
    run_vec({$realtobits(-2147483648.5), $realtobits(2147483647.5)}, 1, 0, 2'b00, "R6 dp edge");
    run_vec({$realtobits(-2147483648.5), $realtobits(2147483647.5)}, 1, 1, 2'b00, "R5 dp edge trunc");
    chk("R5 dp trunc values", 128'(res_o[63:0]), 128'({32'h8000_0000, 32'h7FFF_FFFF}));
    run_vec({$realtobits(-7.0), $realtobits(3.0)}, 1, 0, 2'b10, "R7 dp exact");
    chk("R7 exact no flag", 128'(inexact_o), 128'(0));

    // R9: hold while valid_i low
    held = res_o;
    @(negedge clk_i);
    src_i = ~src_i; dbl_i = ~dbl_i; valid_i = 0;
    @(negedge clk_i);
    chk("R9 hold res", res_o, held);
    chk("R9 hold valid_o", 128'(valid_o), 128'(0));

    // random mix
    for (int n = 0; n < 400; n++) begin
      bit dbl;
      logic [127:0] s;
      dbl = 1'($urandom);
      if (dbl) s = {rnd_dp(), rnd_dp()};
      else s = {rnd_sp(), rnd_sp(), rnd_sp(), rnd_sp()};
      run_vec(s, dbl, ($urandom % 4) == 0, 2'($urandom), "R4 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule